// File: doc/BRIEF.md
# Calendar alarm comparator

This block watches the calendar counter of a real-time clock and signals when the running time reaches a programmed alarm moment. Software loads one alarm byte for each calendar field (seconds, minutes, hours with a PM bit, weekday, day of month, month, year), all in the same BCD layout the counter uses. Each byte carries its own compare enable in bit 7, except the year, whose enable lives in a separate byte. Only the enabled fields take part in the match. The test is made once per second, on the one-second tick from the counter.

On a match the block sets a sticky alarm flag. The flag stays set until software writes a zero to it. The interrupt line is the flag gated by an interrupt enable bit. Rewriting any alarm byte disarms the comparison until two 1/64 s periodic ticks have arrived, so a half-written alarm can never fire. Read-back of the alarm bytes lags a write: the three reads that follow it still return the old contents.

The register port is a plain byte-wide strobe interface. A write or read is accepted in the cycle its strobe is high, with no back-pressure and no wait states, and read data is combinational from the address. The counter inputs and ticks are plain control pins with no handshake.

Top module: `cal_alarm_cmp`

## Requirements
- R1: After reset the alarm flag and interrupt are low, and every address 0 to 9 reads 0x00, so all compare enables are off.
- R2: Addresses 0 to 6 hold the alarm values for seconds (7 bits), minutes (7), hours (7, bit 6 = PM), weekday (3), day (6), month (5) and year (8). Bit 7 of addresses 0 to 5 is that field's compare enable. Bit 7 of address 7 enables the year. Bits a field does not use read as 0, so writing 0xFF to addresses 0 to 7 reads back FF, FF, FF, 87, BF, 9F, FF, 80.
- R3: When the comparison is armed and the one-second tick is high, and every enabled field equals the matching counter field (the hour compare includes the PM bit), the flag is set in the next cycle.
- R4: A field whose enable is clear does not take part: a mismatch in it does not block a match.
- R5: With no field enabled, no match ever occurs.
- R6: A match is tested only in cycles where the one-second tick is high. Equal fields without a tick leave the flag unchanged.
- R7: A write to any of addresses 0 to 7 disarms the comparison. It re-arms after two periodic-tick pulses have followed that write.
- R8: The flag at address 8, bit 0, is sticky. Writing 0 there clears it, and writing 1 has no effect. A match in the same cycle as a clear leaves the flag set.
- R9: The interrupt output equals the flag AND the interrupt enable at address 9, bit 0. That enable reads back at the same bit.
- R10: After a write to addresses 0 to 7, the next three register reads of any address return the alarm bytes as they were before the write. From the fourth read on, the new contents are returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-second tick pulse from the calendar counter |
| per_tick | input | 1 | 1/64 s periodic tick pulse |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 7 | Current hours, BCD, bit 6 = PM |
| now_wday | input | 3 | Current weekday |
| now_day | input | 6 | Current day of month, BCD |
| now_mon | input | 5 | Current month, BCD |
| now_year | input | 8 | Current year, BCD |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from address |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
A register write takes effect at the clock edge where its strobe is high. Read data reflects the state before that edge, in the same cycle. The flag rises at the edge that samples a matching one-second tick, and the interrupt follows the flag and the enable with no further register. The bench changes inputs on falling edges and reads results at the next falling edge, one edge after the stimulus. Every expected flag, interrupt and read-back value is computed from the enable pattern and the mismatching field that were driven.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int NUM_CFG    = NUM_FIELDS + 1;
  localparam int ADDR_W     = 4;
  localparam int CFG_IW     = $clog2(NUM_CFG);

  localparam int W_SEC  = 7;
  localparam int W_MIN  = 7;
  localparam int W_HOUR = 7;
  localparam int W_WDAY = 3;
  localparam int W_DAY  = 6;
  localparam int W_MON  = 5;
  localparam int W_YEAR = 8;

  localparam logic [ADDR_W-1:0] ADR_STAT = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 4'd9;

  function automatic int field_width(input int idx);
    case (idx)
      0:       return W_SEC;
      1:       return W_MIN;
      2:       return W_HOUR;
      3:       return W_WDAY;
      4:       return W_DAY;
      5:       return W_MON;
      default: return W_YEAR;
    endcase
  endfunction

  function automatic logic [7:0] value_mask(input int idx);
    return 8'((1 << field_width(idx)) - 1);
  endfunction

  // Bits kept on a write to configuration byte idx
  function automatic logic [7:0] store_mask(input int idx);
    if (idx < NUM_FIELDS - 1) return value_mask(idx) | 8'h80;
    else if (idx == NUM_FIELDS - 1) return value_mask(idx);
    else return 8'h80;
  endfunction
endpackage

// File: rtl/cal_alarm_cfg.sv
module cal_alarm_cfg
  import cal_alarm_pkg::*;
#(
  parameter int READ_LAG = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_wr,
  input  logic [CFG_IW-1:0]            cfg_idx,
  input  logic [7:0]                   wdata,
  input  logic                         rd_any,
  output logic [NUM_CFG-1:0][7:0]      live,
  output logic [NUM_CFG-1:0][7:0]      shown
);
  localparam int LAG_W = (READ_LAG < 1) ? 1 : $clog2(READ_LAG + 1);

  logic [LAG_W-1:0] pend_q;
  logic             copy;

  // Mirror follows live once the pending read count has run out
  assign copy = !cfg_wr && ((pend_q == '0) || (rd_any && pend_q == LAG_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n)                  pend_q <= '0;
    else if (cfg_wr)             pend_q <= LAG_W'(READ_LAG);
    else if (rd_any && pend_q != '0) pend_q <= pend_q - LAG_W'(1);
  end

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live[i]  <= '0;
        shown[i] <= '0;
      end else begin
        if (cfg_wr && cfg_idx == CFG_IW'(i)) live[i] <= wdata & store_mask(i);
        if (copy) shown[i] <= live[i];
      end
    end
  end
endmodule

// File: rtl/cal_alarm_arm.sv
module cal_alarm_arm #(
  parameter int SETTLE_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic per_tick,
  output logic armed
);
  localparam int CW = (SETTLE_TICKS < 1) ? 1 : $clog2(SETTLE_TICKS + 1);

  logic [CW-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      wait_q <= '0;
    else if (cfg_wr)                 wait_q <= CW'(SETTLE_TICKS);
    else if (per_tick && wait_q != '0) wait_q <= wait_q - CW'(1);
  end

  assign armed = (wait_q == '0);
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
(
  input  logic [NUM_CFG-1:0][7:0]    cfg,
  input  logic [NUM_FIELDS-1:0][7:0] now_b,
  output logic                       hit
);
  logic [NUM_FIELDS-1:0] en;
  logic [NUM_FIELDS-1:0] eq;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    if (i == NUM_FIELDS - 1) begin : g_year
      // year enable byte keeps only bit 7, so any set bit is the enable
      assign en[i] = |cfg[NUM_CFG-1];
    end else begin : g_own
      assign en[i] = cfg[i][7];
    end
    assign eq[i] = ((cfg[i] ^ now_b[i]) & value_mask(i)) == 8'h00;
  end

  assign hit = (|en) && (&(~en | eq));
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
#(
  parameter int SETTLE_TICKS = 2,
  parameter int READ_LAG     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              per_tick,
  input  logic [W_SEC-1:0]  now_sec,
  input  logic [W_MIN-1:0]  now_min,
  input  logic [W_HOUR-1:0] now_hour,
  input  logic [W_WDAY-1:0] now_wday,
  input  logic [W_DAY-1:0]  now_day,
  input  logic [W_MON-1:0]  now_mon,
  input  logic [W_YEAR-1:0] now_year,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              alarm_flag,
  output logic              alarm_irq
);
  logic                         cfg_wr, armed, hit, set_match, clr_flag;
  logic                         irq_en_q, flag_q;
  logic [NUM_CFG-1:0][7:0]      live, shown;
  logic [NUM_FIELDS-1:0][7:0]   now_b;

  assign cfg_wr = reg_wr && (reg_addr < ADDR_W'(NUM_CFG));

  assign now_b[0] = 8'(now_sec);
  assign now_b[1] = 8'(now_min);
  assign now_b[2] = 8'(now_hour);
  assign now_b[3] = 8'(now_wday);
  assign now_b[4] = 8'(now_day);
  assign now_b[5] = 8'(now_mon);
  assign now_b[6] = 8'(now_year);

  cal_alarm_cfg #(.READ_LAG(READ_LAG)) cfg_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(reg_addr[CFG_IW-1:0]),
    .wdata(reg_wdata), .rd_any(reg_rd), .live(live), .shown(shown)
  );

  cal_alarm_arm #(.SETTLE_TICKS(SETTLE_TICKS)) arm_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .per_tick(per_tick), .armed(armed)
  );

  cal_alarm_match match_i (.cfg(live), .now_b(now_b), .hit(hit));

  assign set_match = sec_tick && armed && hit && !cfg_wr;
  assign clr_flag  = reg_wr && (reg_addr == ADR_STAT) && !reg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q   <= 1'b0;
      irq_en_q <= 1'b0;
    end else begin
      if (set_match)     flag_q <= 1'b1;
      else if (clr_flag) flag_q <= 1'b0;
      if (reg_wr && reg_addr == ADR_CTRL) irq_en_q <= reg_wdata[0];
    end
  end

  always_comb begin
    if (reg_addr < ADDR_W'(NUM_CFG)) reg_rdata = shown[reg_addr[CFG_IW-1:0]];
    else if (reg_addr == ADR_STAT)   reg_rdata = {7'd0, flag_q};
    else if (reg_addr == ADR_CTRL)   reg_rdata = {7'd0, irq_en_q};
    else                             reg_rdata = 8'h00;
  end

  assign alarm_flag = flag_q;
  assign alarm_irq  = flag_q & irq_en_q;
endmodule

// File: rtl/cal_alarm_cmp_chk.sv
module cal_alarm_cmp_chk
  import cal_alarm_pkg::*;
#(
  parameter int SETTLE_TICKS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sec_tick,
  input logic              per_tick,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              wbit0,
  input logic              alarm_flag,
  input logic              alarm_irq
);
  localparam int CW = (SETTLE_TICKS < 1) ? 1 : $clog2(SETTLE_TICKS + 1);

  logic          cfg_w, clr_w;
  logic [CW-1:0] ticks_q;

  assign cfg_w = reg_wr && (reg_addr < ADDR_W'(NUM_CFG));
  assign clr_w = reg_wr && (reg_addr == ADR_STAT) && !wbit0;

  // Periodic ticks seen since the last configuration write, saturating
  always_ff @(posedge clk) begin
    if (!rst_n)                                     ticks_q <= CW'(SETTLE_TICKS);
    else if (cfg_w)                                 ticks_q <= '0;
    else if (per_tick && ticks_q < CW'(SETTLE_TICKS)) ticks_q <= ticks_q + CW'(1);
  end

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_flag && !clr_w |=> alarm_flag);

  a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w && !sec_tick |=> !alarm_flag);

  a_r6_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(sec_tick));

  a_r7_settled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(ticks_q) == CW'(SETTLE_TICKS));

  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> alarm_flag);
endmodule

bind cal_alarm_cmp cal_alarm_cmp_chk #(.SETTLE_TICKS(SETTLE_TICKS)) chk_i (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .per_tick(per_tick),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .wbit0(reg_wdata[0]),
  .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
);

// File: tb/cal_alarm_cmp_tb_top.sv
module cal_alarm_cmp_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0, per_tick = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       alarm_flag, alarm_irq;
  logic [7:0] cur [7];
  int         errs = 0, nchk = 0;
  bit         done = 1'b0;

  // Alarm values (no enable bit): 45 s, 30 min, PM 12 h, weekday 3, day 28, month 11, year 24
  localparam logic [7:0] AVAL [7] = '{8'h45, 8'h30, 8'h52, 8'h03, 8'h28, 8'h11, 8'h24};
  localparam logic [7:0] RMSK [8] = '{8'hFF, 8'hFF, 8'hFF, 8'h87, 8'hBF, 8'h9F, 8'hFF, 8'h80};

  always #5 clk = ~clk;

  cal_alarm_cmp dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .per_tick(per_tick),
    .now_sec(cur[0][6:0]), .now_min(cur[1][6:0]), .now_hour(cur[2][6:0]),
    .now_wday(cur[3][2:0]), .now_day(cur[4][5:0]), .now_mon(cur[5][4:0]),
    .now_year(cur[6]), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alarm_flag(alarm_flag),
    .alarm_irq(alarm_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic pulse_per();
    @(negedge clk); per_tick = 1'b1;
    @(negedge clk); per_tick = 1'b0;
  endtask

  task automatic pulse_sec();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic prog(input logic [6:0] em, input int nt);
    for (int i = 0; i < 6; i++) wr(4'(i), (em[i] ? 8'h80 : 8'h00) | AVAL[i]);
    wr(4'd6, AVAL[6]);
    wr(4'd7, em[6] ? 8'h80 : 8'h00);
    repeat (nt) pulse_per();
  endtask

  // Counter equals the alarm except field mm (7 = none); the hour differs in its PM bit
  task automatic set_cur(input int mm);
    for (int i = 0; i < 7; i++)
      cur[i] = (i == mm) ? (AVAL[i] ^ ((i == 2) ? 8'h40 : 8'h01)) : AVAL[i];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; nchk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    set_cur(7);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 flag", {7'd0, alarm_flag}, 8'h00);
    chk("R1 irq", {7'd0, alarm_irq}, 8'h00);
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), d); chk("R1 readback", d, 8'h00);
    end

    // R10 read-back lag
    wr(4'd0, 8'hC5);
    for (int k = 0; k < 3; k++) begin
      rd(4'd0, d); chk("R10 stale read", d, 8'h00);
    end
    rd(4'd0, d); chk("R10 fresh read", d, 8'hC5);

    // R2 field masks, R9 enable readback
    for (int a = 0; a < 8; a++) wr(4'(a), 8'hFF);
    wr(4'd9, 8'hFF);
    repeat (3) rd(4'd9, d);
    for (int a = 0; a < 8; a++) begin
      rd(4'(a), d); chk("R2 field mask", d, RMSK[a]);
    end
    rd(4'd9, d); chk("R9 enable readback", d, 8'h01);

    // R3 R4 R5 sweep over enable patterns and mismatching field, interrupt enabled
    for (int em = 0; em < 128; em++) begin
      for (int mm = 0; mm < 8; mm++) begin
        logic exp_f;
        wr(4'd8, 8'h00);
        prog(7'(em), 2);
        set_cur(mm);
        pulse_sec();
        exp_f = (em != 0) && (mm == 7 || !em[mm]);
        chk(em == 0 ? "R5 no enables" : (mm == 7 ? "R3 full match" : "R4 field gating"),
            {7'd0, alarm_flag}, {7'd0, exp_f});
        chk("R9 irq enabled", {7'd0, alarm_irq}, {7'd0, exp_f});
      end
    end

    // R6 no tick, no match
    wr(4'd8, 8'h00);
    prog(7'h7F, 2);
    set_cur(7);
    repeat (6) @(negedge clk);
    chk("R6 no tick", {7'd0, alarm_flag}, 8'h00);

    // R7 settle window
    prog(7'h7F, 1);
    pulse_sec();
    chk("R7 one tick only", {7'd0, alarm_flag}, 8'h00);
    pulse_per();
    pulse_sec();
    chk("R7 two ticks", {7'd0, alarm_flag}, 8'h01);

    // R8 sticky flag
    wr(4'd8, 8'h01);
    chk("R8 write one ignored", {7'd0, alarm_flag}, 8'h01);
    rd(4'd8, d); chk("R8 status readback", d, 8'h01);
    pulse_sec();
    set_cur(0);
    pulse_sec();
    chk("R8 held without match", {7'd0, alarm_flag}, 8'h01);
    wr(4'd8, 8'h00);
    chk("R8 cleared", {7'd0, alarm_flag}, 8'h00);
    set_cur(7);
    @(negedge clk); sec_tick = 1'b1; reg_wr = 1'b1; reg_addr = 4'd8; reg_wdata = 8'h00;
    @(negedge clk); sec_tick = 1'b0; reg_wr = 1'b0;
    chk("R8 set beats clear", {7'd0, alarm_flag}, 8'h01);

    // R9 interrupt gating
    wr(4'd9, 8'h00);
    chk("R9 irq masked", {7'd0, alarm_irq}, 8'h00);
    chk("R9 flag kept", {7'd0, alarm_flag}, 8'h01);
    wr(4'd9, 8'h01);
    chk("R9 irq unmasked", {7'd0, alarm_irq}, 8'h01);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule